// File: doc/BRIEF.md
# Auto-Acknowledging Prioritized Interrupt Controller

This block gathers a parameterized set of level-sensitive hardware interrupt lines and delivers them to a parameterized number of CPUs. Each line has a software-trigger bit that is ORed with the hardware level. It also has a mask bit, and a target register that selects the CPUs that may take it. Every CPU has an interrupt output. That output is high while any unmasked, pending line is steered to that CPU.

Each CPU has its own event register. Reading it returns the lowest-numbered eligible line and masks that line on the same clock edge, so the read itself acknowledges the interrupt. Software ends the service of a line by writing its bit to the mask-clear register. All registers sit on a plain 32-bit read/write bus. Read data appears one cycle after the request.

Top module: `auto_ack_intc`

## Requirements
- R1: After reset every line is masked, every software-trigger bit is clear, every target register reads 1 (CPU 0), and all `irq_o` bits are low.
- R2: Line n is pending when `(irq_i[n] | soft[n]) & ~mask[n]`. `irq_o[c]` is high exactly when some pending line has bit c set in its target register.
- R3: Writes to mask-set (0x180 + 4*w) set mask bits and writes to mask-clear (0x1C0 + 4*w) clear them. Line n is word w = n>>5, bit n&31. Zero bits in the write data change nothing. Reading either address returns that mask word.
- R4: Writes to soft-set (0x100 + 4*w) set software-trigger bits and writes to soft-clear (0x140 + 4*w) clear them, using the same word and bit mapping and write-1 rule. Reading either address returns that software word.
- R5: When several lines are eligible for a CPU, the event read reports the lowest-numbered one.
- R6: The event register of CPU c is at 0x000 + 4*c. A non-empty result is bits 31:24 = 0, bits 23:16 = 1 and bits 15:0 = line number. The result is 0x00000000 when nothing is eligible.
- R7: A non-empty event read sets the mask bit of the reported line on the same clock edge that latches the read data.
- R8: The target register of line n is at 0x400 + 4*n and holds a one-hot CPU bit in bits N_CPU-1:0. A line is seen only by the CPUs whose bits are set.
- R9: Read data is registered on the request edge and is valid from the following cycle. An event read reflects line levels present in the request cycle.
- R10: An event read that returns zero leaves every mask bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_IRQ | Level-sensitive hardware lines |
| bus_req_i | input | 1 | Bus access request for one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | N_CPU | Per-CPU interrupt request |

## Verification
An event read and a change of a hardware line can fall in the same cycle. The bench drives a new, lower-numbered line high in the same cycle as the read request, while a higher-numbered line is already pending. The check passes when the read reports the new line and masks only that line. The older line must stay unmasked and keep `irq_o` high, and a second read must then return it.

// File: rtl/auto_ack_intc_pkg.sv
package auto_ack_intc_pkg;
  localparam int OFS_EVENT   = 'h000;
  localparam int OFS_SW_SET  = 'h100;
  localparam int OFS_SW_CLR  = 'h140;
  localparam int OFS_MSK_SET = 'h180;
  localparam int OFS_MSK_CLR = 'h1C0;
  localparam int OFS_TARGET  = 'h400;

  localparam logic [7:0] EV_KIND_HW = 8'd1;

  function automatic logic [31:0] ev_word(input logic [15:0] line);
    return {8'd0, EV_KIND_HW, line};
  endfunction
endpackage

// File: rtl/intc_line_bank.sv
module intc_line_bank #(
  parameter int N_IRQ = 64,
  localparam int N_WORD = (N_IRQ + 31) / 32,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_WORD-1:0] sw_set_i,
  input  logic [N_WORD-1:0] sw_clr_i,
  input  logic [N_WORD-1:0] msk_set_i,
  input  logic [N_WORD-1:0] msk_clr_i,
  input  logic [31:0]       wdata_i,
  input  logic              amask_en_i,
  input  logic [IDX_W-1:0]  amask_idx_i,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [N_IRQ-1:0]  sw_o,
  output logic [N_IRQ-1:0]  pend_o
);
  logic [N_IRQ-1:0] mask_q, sw_q;

  for (genvar n = 0; n < N_IRQ; n++) begin : g_line
    localparam int W = n / 32;
    localparam int B = n % 32;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[n] <= 1'b1;
        sw_q[n]   <= 1'b0;
      end else begin
        if (msk_clr_i[W] && wdata_i[B]) mask_q[n] <= 1'b0;
        // auto-mask on event read
        if ((msk_set_i[W] && wdata_i[B]) ||
            (amask_en_i && amask_idx_i == IDX_W'(n))) mask_q[n] <= 1'b1;
        if (sw_clr_i[W] && wdata_i[B]) sw_q[n] <= 1'b0;
        if (sw_set_i[W] && wdata_i[B]) sw_q[n] <= 1'b1;
      end
    end
  end

  assign mask_o = mask_q;
  assign sw_o   = sw_q;
  assign pend_o = (irq_i | sw_q) & ~mask_q;
endmodule

// File: rtl/intc_target_bank.sv
module intc_target_bank #(
  parameter int N_IRQ = 64,
  parameter int N_CPU = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_IRQ-1:0]         wr_stb_i,
  input  logic [N_CPU-1:0]         wdata_i,
  output logic [N_IRQ*N_CPU-1:0]   tgt_o
);
  for (genvar n = 0; n < N_IRQ; n++) begin : g_tgt
    logic [N_CPU-1:0] tgt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          tgt_q <= N_CPU'(1);
      else if (wr_stb_i[n]) tgt_q <= wdata_i;
    end
    assign tgt_o[n*N_CPU +: N_CPU] = tgt_q;
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N_IRQ = 64,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int n = N_IRQ - 1; n >= 0; n--) begin
      if (req_i[n]) idx_o = IDX_W'(n);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/auto_ack_intc.sv
module auto_ack_intc
  import auto_ack_intc_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_CPU-1:0]  irq_o
);
  localparam int N_WORD = (N_IRQ + 31) / 32;
  localparam int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic wr, rd;
  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  logic [N_WORD-1:0] sw_set_stb, sw_clr_stb, msk_set_stb, msk_clr_stb;
  logic [N_IRQ-1:0]  tgt_stb;
  logic [N_CPU-1:0]  ev_hit;

  for (genvar w = 0; w < N_WORD; w++) begin : g_wdec
    assign sw_set_stb[w]  = wr && bus_addr_i == ADDR_W'(OFS_SW_SET + 4*w);
    assign sw_clr_stb[w]  = wr && bus_addr_i == ADDR_W'(OFS_SW_CLR + 4*w);
    assign msk_set_stb[w] = wr && bus_addr_i == ADDR_W'(OFS_MSK_SET + 4*w);
    assign msk_clr_stb[w] = wr && bus_addr_i == ADDR_W'(OFS_MSK_CLR + 4*w);
  end

  for (genvar n = 0; n < N_IRQ; n++) begin : g_tdec
    assign tgt_stb[n] = wr && bus_addr_i == ADDR_W'(OFS_TARGET + 4*n);
  end

  logic             amask_en;
  logic [IDX_W-1:0] amask_idx;
  logic [N_IRQ-1:0] mask_w, sw_w, pend_w;

  intc_line_bank #(.N_IRQ(N_IRQ)) u_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .sw_set_i    (sw_set_stb),
    .sw_clr_i    (sw_clr_stb),
    .msk_set_i   (msk_set_stb),
    .msk_clr_i   (msk_clr_stb),
    .wdata_i     (bus_wdata_i),
    .amask_en_i  (amask_en),
    .amask_idx_i (amask_idx),
    .mask_o      (mask_w),
    .sw_o        (sw_w),
    .pend_o      (pend_w)
  );

  logic [N_IRQ*N_CPU-1:0] tgt_w;

  intc_target_bank #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_tgt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (tgt_stb),
    .wdata_i  (bus_wdata_i[N_CPU-1:0]),
    .tgt_o    (tgt_w)
  );

  logic [N_CPU-1:0]            cpu_valid;
  logic [N_CPU-1:0][IDX_W-1:0] cpu_idx;

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [N_IRQ-1:0] elig;
    for (genvar n = 0; n < N_IRQ; n++) begin : g_el
      assign elig[n] = pend_w[n] & tgt_w[n*N_CPU + c];
    end
    intc_prio_pick #(.N_IRQ(N_IRQ)) u_pick (
      .req_i   (elig),
      .valid_o (cpu_valid[c]),
      .idx_o   (cpu_idx[c])
    );
    assign ev_hit[c] = rd && bus_addr_i == ADDR_W'(OFS_EVENT + 4*c);
  end

  assign irq_o = cpu_valid;

  always_comb begin
    amask_en  = 1'b0;
    amask_idx = '0;
    for (int c = 0; c < N_CPU; c++) begin
      if (ev_hit[c] && cpu_valid[c]) begin
        amask_en  = 1'b1;
        amask_idx = cpu_idx[c];
      end
    end
  end

  logic [N_WORD*32-1:0] mask_pad, sw_pad;
  assign mask_pad = (N_WORD*32)'(mask_w);
  assign sw_pad   = (N_WORD*32)'(sw_w);

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int c = 0; c < N_CPU; c++) begin
      if (bus_addr_i == ADDR_W'(OFS_EVENT + 4*c))
        rd_word = cpu_valid[c] ? ev_word(16'(cpu_idx[c])) : 32'd0;
    end
    for (int w = 0; w < N_WORD; w++) begin
      if (bus_addr_i == ADDR_W'(OFS_SW_SET + 4*w) || bus_addr_i == ADDR_W'(OFS_SW_CLR + 4*w))
        rd_word = sw_pad[w*32 +: 32];
      if (bus_addr_i == ADDR_W'(OFS_MSK_SET + 4*w) || bus_addr_i == ADDR_W'(OFS_MSK_CLR + 4*w))
        rd_word = mask_pad[w*32 +: 32];
    end
    for (int n = 0; n < N_IRQ; n++) begin
      if (bus_addr_i == ADDR_W'(OFS_TARGET + 4*n))
        rd_word = 32'(tgt_w[n*N_CPU +: N_CPU]);
    end
  end

  logic [31:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_word;
  end
  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/auto_ack_intc_chk.sv
module auto_ack_intc_chk
  import auto_ack_intc_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IRQ-1:0]  irq_i,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [N_CPU-1:0]  irq_o,
  input logic [N_IRQ-1:0]  mask_w,
  input logic [N_IRQ-1:0]  sw_w
);
  localparam int N_WORD = (N_IRQ + 31) / 32;
  localparam int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic ev_rd;
  assign ev_rd = bus_req_i && !bus_we_i && (int'(bus_addr_i) < 4*N_CPU) && bus_addr_i[1:0] == 2'b00;

  // R2
  irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|((irq_i | sw_w) & ~mask_w)));

  // R6
  event_format_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rd |=> (bus_rdata_o[31:24] == 8'd0 &&
               (bus_rdata_o == 32'd0 || bus_rdata_o[23:16] == EV_KIND_HW)));

  // R7
  read_masks_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rd |=> (bus_rdata_o == 32'd0 || mask_w[bus_rdata_o[IDX_W-1:0]]));

  for (genvar c = 0; c < N_CPU; c++) begin : g_c
    // R10
    empty_read_keeps_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && !bus_we_i && bus_addr_i == ADDR_W'(OFS_EVENT + 4*c) && !irq_o[c])
        |=> mask_w == $past(mask_w));
  end

  for (genvar w = 0; w < N_WORD; w++) begin : g_w
    localparam int HI = (w*32 + 32 > N_IRQ) ? N_IRQ : w*32 + 32;
    // R3
    mask_clr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_MSK_CLR + 4*w))
        |=> (mask_w[HI-1:w*32] & $past(bus_wdata_i[HI-w*32-1:0])) == '0);
    // R4
    sw_set_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_SW_SET + 4*w))
        |=> (~sw_w[HI-1:w*32] & $past(bus_wdata_i[HI-w*32-1:0])) == '0);
  end
endmodule

bind auto_ack_intc auto_ack_intc_chk #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .mask_w      (mask_w),
  .sw_w        (sw_w)
);

// File: tb/auto_ack_intc_tb.sv
`timescale 1ns/1ps
module auto_ack_intc_tb;
  localparam int N_IRQ = 64;
  localparam int N_CPU = 4;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_IRQ-1:0] irq_i = '0;
  logic bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [N_CPU-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  auto_ack_intc #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = ADDR_W'(addr); bus_wdata_i = data;
    @(negedge clk);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = ADDR_W'(addr);
    @(negedge clk);
    bus_req_i = 1'b0;
    data = bus_rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd('h180, d); check("R1 mask word0", d, 32'hFFFF_FFFF);
    bus_rd('h184, d); check("R1 mask word1", d, 32'hFFFF_FFFF);
    bus_rd('h100, d); check("R1 soft word0", d, 32'h0);
    bus_rd('h428, d); check("R1 target line10", d, 32'h1);
    check("R1 irq_o", 32'(irq_o), 32'h0);
    bus_rd('h000, d); check("R6 empty event", d, 32'h0);
    bus_rd('h1C0, d); check("R10 mask after empty read", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    irq_i[3] = 1'b1;
    @(negedge clk); check("R2 masked line no irq", 32'(irq_o), 32'h0);
    bus_wr('h1C0, 32'h0);
    bus_rd('h180, d); check("R3 zero write no effect", d, 32'hFFFF_FFFF);
    bus_wr('h1C0, 32'h8);
    bus_rd('h180, d); check("R3 clear bit3", d, 32'hFFFF_FFF7);
    check("R2 irq_o cpu0", 32'(irq_o), 32'h1);
    bus_wr('h180, 32'h8);
    check("R3 mask set drops irq", 32'(irq_o), 32'h0);
    bus_wr('h1C0, 32'h8);
    bus_rd('h000, d); check("R6 event word line3", d, 32'h0001_0003);
    check("R7 irq drops after read", 32'(irq_o), 32'h0);
    bus_rd('h180, d); check("R7 line3 masked", d, 32'hFFFF_FFFF);
    irq_i[3] = 1'b0;
  endtask

  task automatic t_prio();
    logic [31:0] d;
    bus_wr('h1C0, 32'h80);
    bus_wr('h1C4, 32'h102);
    bus_wr('h104, 32'h102);
    bus_wr('h100, 32'h80);
    bus_rd('h104, d); check("R4 soft word1", d, 32'h102);
    bus_rd('h140, d); check("R4 soft word0 via clr addr", d, 32'h80);
    check("R2 soft trigger irq", 32'(irq_o), 32'h1);
    bus_rd('h000, d); check("R5 first line7", d, 32'h0001_0007);
    bus_rd('h000, d); check("R5 second line33", d, 32'h0001_0021);
    bus_rd('h000, d); check("R5 third line40", d, 32'h0001_0028);
    bus_rd('h000, d); check("R6 drained", d, 32'h0);
    bus_rd('h184, d); check("R7 word1 all masked", d, 32'hFFFF_FFFF);
    bus_wr('h144, 32'h100);
    bus_wr('h140, 32'h80);
    bus_rd('h104, d); check("R4 soft clear bit40", d, 32'h2);
    bus_rd('h100, d); check("R4 soft clear bit7", d, 32'h0);
    bus_wr('h144, 32'h2);
  endtask

  task automatic t_target();
    logic [31:0] d;
    bus_wr('h428, 32'h4);
    bus_rd('h428, d); check("R8 target readback", d, 32'h4);
    irq_i[10] = 1'b1;
    bus_wr('h1C0, 32'h400);
    check("R8 irq to cpu2 only", 32'(irq_o), 32'h4);
    bus_rd('h000, d); check("R8 cpu0 sees nothing", d, 32'h0);
    bus_rd('h180, d); check("R10 line10 still unmasked", {31'd0, d[10]}, 32'h0);
    bus_rd('h008, d); check("R8 cpu2 event", d, 32'h0001_000A);
    check("R7 cpu2 irq drops", 32'(irq_o), 32'h0);
    irq_i[10] = 1'b0;
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    bus_wr('h1C0, 32'h0010_0020);
    irq_i[20] = 1'b1;
    @(negedge clk); check("R2 line20 irq", 32'(irq_o), 32'h1);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = ADDR_W'('h000);
    irq_i[5] = 1'b1;
    @(negedge clk);
    bus_req_i = 1'b0;
    check("R9 read sees line raised same cycle", bus_rdata_o, 32'h0001_0005);
    bus_rd('h180, d);
    check("R7 line5 masked", {31'd0, d[5]}, 32'h1);
    check("R7 line20 untouched", {31'd0, d[20]}, 32'h0);
    check("R2 irq stays for line20", 32'(irq_o), 32'h1);
    bus_rd('h000, d); check("R5 then line20", d, 32'h0001_0014);
    irq_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_mask();
    t_prio();
    t_target();
    t_same_cycle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule